// File: doc/BRIEF.md
# Loader Byte Exchange Data Register

This block is the ten-bit scan data register used while the chip runs its serial loader. With the debug instruction selected in the test access port, each data-register scan moves one byte in each direction at once. The host shifts a byte in, and the CPU sees it in a receive buffer. The scan also returns the byte that the CPU staged earlier in a holding register. The two low bits of each scan carry handshake status, so the host can tell whether the outgoing byte was valid and whether its previous byte is still unread.

The TAP state machine lives elsewhere. It supplies the decoded instruction select and the Capture-DR, Shift-DR and Update-DR state flags, all timed to TCK. The update event crosses into the system-clock domain through a toggle, a synchroniser and an edge detector. It raises a one-cycle receive strobe there. TCK must stay below one eighth of the system clock, so data handed across the boundary is stable when it is sampled.

Top module: `loader_xchg_dr`

## Requirements
- R1: After rst_ni is asserted, rx_data_o is 0, rx_valid_o is 0, txc_o is 0 and rx_strobe_o is 0.
- R2: On a rising TCK edge with sel_i and capture_dr_i high, the register loads the holding byte into bits 9:2, txc_o into bit 1 and rx_valid_o into bit 0. On each rising TCK edge with sel_i and shift_dr_i high, the register shifts toward bit 0. tdi_i enters at bit 9 and tdo_o always shows bit 0, so the data leaves LSB first.
- R3: On a falling TCK edge with sel_i and update_dr_i high, bits 9:2 of the register become the received byte. The byte appears on rx_data_o in the system domain together with exactly one rx_strobe_o pulse, and that pulse lasts one clock cycle.
- R4: The cycle after rx_strobe_o, txc_o is 0, unless txc_set_i was high in that same cycle. The cycle after txc_set_i is high, txc_o is 1.
- R5: The cycle after rx_strobe_o, rx_valid_o is 1. The cycle after cpu_rd_i is high without rx_strobe_o, rx_valid_o is 0.
- R6: cpu_wr_i loads cpu_wdata_i into the holding register. The next capture returns that byte.
- R7: With sel_i low, capture, shift and update have no effect: rx_data_o does not change and no rx_strobe_o pulse occurs.
- R8: tap_rst_ni low clears the shift register, so tdo_o is 0, and produces no rx_strobe_o pulse.
- R9: rx_data_o changes only in the cycle after rx_strobe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, async, active low |
| tck_i | input | 1 | Test clock |
| tap_rst_ni | input | 1 | TAP logic reset, async, active low |
| sel_i | input | 1 | Debug instruction decoded in IR |
| capture_dr_i | input | 1 | TAP in Capture-DR |
| shift_dr_i | input | 1 | TAP in Shift-DR |
| update_dr_i | input | 1 | TAP in Update-DR |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0) |
| cpu_wr_i | input | 1 | CPU write to holding register |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | CPU read of receive buffer |
| txc_set_i | input | 1 | CPU marks outgoing byte valid |
| rx_data_o | output | 8 | Receive buffer |
| rx_valid_o | output | 1 | Unread receive byte flag |
| txc_o | output | 1 | Transmit-complete flag |
| rx_strobe_o | output | 1 | One-cycle receive pulse |

## Verification
The assertions check the system-domain flag rules on every cycle. These are the set and clear priorities of txc_o and rx_valid_o, the single-cycle width of rx_strobe_o, and that rx_data_o holds its value outside a strobe. Only the bench scenarios can show the TCK-side behaviour. That covers the bit order and status layout of a captured word, the arrival of the host byte after a full scan, the lack of effect while the instruction is not selected, and that a TAP reset raises no strobe.

// File: rtl/lx_pkg.sv
package lx_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned STAT_W     = 2;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/lx_tck_shift.sv
module lx_tck_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAT_W = 2,
  localparam int unsigned DR_W  = DATA_W + STAT_W
) (
  input  logic              tck_i,
  input  logic              tap_rst_ni,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DR_W-1:0]   cap_word_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] upd_data_o,
  output logic              upd_tgl_o
);
  logic [DR_W-1:0]   sr_q;
  logic [DATA_W-1:0] upd_q;
  logic              tgl_q;

  always_ff @(posedge tck_i or negedge tap_rst_ni) begin
    if (!tap_rst_ni)               sr_q <= '0;
    else if (sel_i && capture_i)   sr_q <= cap_word_i;
    else if (sel_i && shift_i)     sr_q <= {tdi_i, sr_q[DR_W-1:1]};
  end

  // update on falling TCK; toggle on power-on reset only so a TAP reset raises no strobe
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= '0;
      tgl_q <= 1'b0;
    end else if (sel_i && update_i && tap_rst_ni) begin
      upd_q <= sr_q[DR_W-1:STAT_W];
      tgl_q <= ~tgl_q;
    end
  end

  assign tdo_o      = sr_q[0];
  assign upd_data_o = upd_q;
  assign upd_tgl_o  = tgl_q;
endmodule

// File: rtl/lx_tgl_sync.sv
module lx_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= tgl_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], tgl_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign pulse_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lx_sys_regs.sv
module lx_sys_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              txc_set_i,
  output logic [DATA_W-1:0] hold_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              txc_o
);
  logic [DATA_W-1:0] hold_q, rx_q;
  logic              rxv_q, txc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rx_q   <= '0;
      rxv_q  <= 1'b0;
      txc_q  <= 1'b0;
    end else begin
      if (cpu_wr_i) hold_q <= cpu_wdata_i;
      if (strobe_i) rx_q <= upd_data_i;
      // new byte beats a concurrent read
      if (strobe_i)      rxv_q <= 1'b1;
      else if (cpu_rd_i) rxv_q <= 1'b0;
      // CPU set beats hardware clear
      if (txc_set_i)     txc_q <= 1'b1;
      else if (strobe_i) txc_q <= 1'b0;
    end
  end

  assign hold_o     = hold_q;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = rxv_q;
  assign txc_o      = txc_q;
endmodule

// File: rtl/loader_xchg_dr.sv
module loader_xchg_dr
  import lx_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF,
  localparam int unsigned DR_W  = DATA_W + STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tck_i,
  input  logic              tap_rst_ni,
  input  logic              sel_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              txc_set_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              txc_o,
  output logic              rx_strobe_o
);
  logic [DATA_W-1:0] hold, upd_data;
  logic              upd_tgl;
  logic [DR_W-1:0]   cap_word;

  // quasi-static across domains given TCK < clk/8
  assign cap_word = {hold, txc_o, rx_valid_o};

  lx_tck_shift #(.DATA_W(DATA_W), .STAT_W(STAT_W)) shift_i (
    .tck_i, .tap_rst_ni, .rst_ni, .sel_i,
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .update_i  (update_dr_i),
    .tdi_i,
    .cap_word_i(cap_word),
    .tdo_o,
    .upd_data_o(upd_data),
    .upd_tgl_o (upd_tgl)
  );

  lx_tgl_sync #(.STAGES(SYNC_N)) sync_i (
    .clk_i, .rst_ni,
    .tgl_i  (upd_tgl),
    .pulse_o(rx_strobe_o)
  );

  lx_sys_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni,
    .strobe_i  (rx_strobe_o),
    .upd_data_i(upd_data),
    .cpu_wr_i, .cpu_wdata_i, .cpu_rd_i, .txc_set_i,
    .hold_o    (hold),
    .rx_data_o, .rx_valid_o, .txc_o
  );
endmodule

// File: rtl/lx_chk.sv
module lx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_strobe_o,
  input logic              txc_set_i,
  input logic              cpu_rd_i,
  input logic              txc_o,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o
);
  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_strobe_o |=> !rx_strobe_o);
  // R4
  txc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_strobe_o && !txc_set_i |=> !txc_o);
  // R4
  txc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txc_set_i |=> txc_o);
  // R5
  rxv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_strobe_o |=> rx_valid_o);
  // R5
  rxv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && !rx_strobe_o |=> !rx_valid_o);
  // R9
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_strobe_o |=> $stable(rx_data_o));
endmodule

bind loader_xchg_dr lx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i, .rst_ni, .rx_strobe_o, .txc_set_i, .cpu_rd_i,
  .txc_o, .rx_valid_o, .rx_data_o
);

// File: tb/loader_xchg_dr_tb_top.sv
module loader_xchg_dr_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, tck = 1'b0, tap_rst_n = 1'b0;
  logic       sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic       tdo, cpu_wr = 1'b0, cpu_rd = 1'b0, txc_set = 1'b0;
  logic [7:0] cpu_wdata = '0, rx_data;
  logic       rx_valid, txc, rx_strobe;
  int         n_chk = 0, n_fail = 0, n_strb = 0;

  always #5 clk = ~clk;

  loader_xchg_dr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck), .tap_rst_ni(tap_rst_n),
    .sel_i(sel), .capture_dr_i(cap), .shift_dr_i(shf), .update_dr_i(upd),
    .tdi_i(tdi), .tdo_o(tdo), .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata),
    .cpu_rd_i(cpu_rd), .txc_set_i(txc_set), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .txc_o(txc), .rx_strobe_o(rx_strobe)
  );

  always @(posedge clk) if (rx_strobe) n_strb++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tck_cyc();
    tck = 1'b1; #80; tck = 1'b0; #80;
  endtask

  task automatic scan(input logic [9:0] din, output logic [9:0] dout);
    @(negedge clk);
    cap = 1'b1; tck_cyc(); cap = 1'b0; shf = 1'b1;
    for (int i = 0; i < 10; i++) begin
      dout[i] = tdo; tdi = din[i]; tck_cyc();
    end
    shf = 1'b0; upd = 1'b1; tck_cyc(); upd = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cpu_pulse(input int kind, input logic [7:0] d);
    @(negedge clk);
    cpu_wdata = d;
    cpu_wr = (kind == 0); cpu_rd = (kind == 1); txc_set = (kind == 2);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0; txc_set = 1'b0;
  endtask

  // {hold byte, host byte, set txc, read after}
  localparam logic [17:0] VEC [6] = '{
    {8'hA5, 8'h3C, 1'b1, 1'b1},
    {8'h00, 8'hFF, 1'b0, 1'b0},
    {8'hFF, 8'h01, 1'b1, 1'b0},
    {8'h81, 8'h80, 1'b0, 1'b1},
    {8'h5A, 8'h00, 1'b1, 1'b1},
    {8'h7E, 8'hC3, 1'b0, 1'b0}
  };

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] dout;
    logic       exp_rxv;
    int         s0;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    // R1
    check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    check(txc == 1'b0, "R1 txc", txc, 0);
    check(rx_strobe == 1'b0, "R1 strobe", rx_strobe, 0);
    rst_n = 1'b1; tap_rst_n = 1'b1; sel = 1'b1;
    exp_rxv = 1'b0;

    foreach (VEC[k]) begin
      logic [7:0] h, m;
      h = VEC[k][17:10]; m = VEC[k][9:2];
      cpu_pulse(0, h);
      if (VEC[k][1]) cpu_pulse(2, 8'h00);
      s0 = n_strb;
      scan({m, 2'b10}, dout);
      // R2, R6
      check(dout == {h, VEC[k][1], exp_rxv}, "R2/R6 captured word", dout, {h, VEC[k][1], exp_rxv});
      // R3
      check(rx_data == m, "R3 rx_data", rx_data, m);
      check(n_strb - s0 == 1, "R3 strobe count", n_strb - s0, 1);
      // R4
      check(txc == 1'b0, "R4 txc cleared", txc, 0);
      // R5
      check(rx_valid == 1'b1, "R5 rx_valid set", rx_valid, 1);
      exp_rxv = 1'b1;
      if (VEC[k][0]) begin
        cpu_pulse(1, 8'h00);
        check(rx_valid == 1'b0, "R5 read clears", rx_valid, 0);
        exp_rxv = 1'b0;
      end
    end

    // R9: CPU activity leaves rx_data alone
    keep = rx_data;
    cpu_pulse(0, 8'h99); cpu_pulse(1, 8'h00); cpu_pulse(2, 8'h00);
    check(rx_data == keep, "R9 rx_data held", rx_data, keep);
    check(txc == 1'b1, "R4 txc set", txc, 1);

    // R7: deselected scan has no effect
    sel = 1'b0; s0 = n_strb;
    scan({8'h44, 2'b11}, dout);
    check(rx_data == keep, "R7 rx_data unchanged", rx_data, keep);
    check(n_strb == s0, "R7 no strobe", n_strb - s0, 0);
    check(txc == 1'b1, "R7 txc kept", txc, 1);
    sel = 1'b1;

    // R8: TAP reset clears shift register, no strobe
    scan({8'h12, 2'b11}, dout);
    check(tdo == 1'b1, "R8 pre-reset tdo", tdo, 1);
    s0 = n_strb;
    @(negedge clk); tap_rst_n = 1'b0;
    repeat (2) @(negedge clk); tap_rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(tdo == 1'b0, "R8 tdo cleared", tdo, 0);
    check(n_strb == s0, "R8 no strobe", n_strb - s0, 0);
    check(rx_data == 8'h12, "R8 rx_data kept", rx_data, 8'h12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule